// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects up to 32 interrupt sources and presents them to a CPU core as two request lines: a normal request and a fast request. Each source has its own mode word and its own 32-bit vector word. The mode word selects the trigger type, either level-high or rising edge, and a 3-bit priority. The controller picks one winner among the sources that are enabled, pending and not routed to the fast line. The winner has the highest priority; on a tie, the lowest source number wins.

The controller holds an 8-entry priority stack. When software acknowledges an interrupt, the controller pushes the winner's priority onto the stack. While a level sits on the stack, the normal line asserts only for a source of strictly higher priority. Each write to the end-of-interrupt register pops one level. By default, reading the vector register is the acknowledge. In protect mode a vector read has no side effect, so a debugger can inspect it safely, and a write to the vector register performs the acknowledge instead. A global mask holds both request lines low.

The register bus is a plain single-cycle port. Every access with `bus_sel` high completes in the cycle it is presented, so the bus has no back-pressure. Read data is combinational from the address. Side effects of a read or write take place at the rising clock edge that ends the access. Word addresses (7 bits):

| Address | Access | Content |
|---|---|---|
| 0x00+n | read/write | mode of source n: bits [2:0] priority (7 = highest), bit 4 = 1 rising edge / 0 level-high |
| 0x20+n | read/write | vector of source n |
| 0x40 | read/write | vector register (acknowledge) |
| 0x41 | read | raw pending bits |
| 0x42 | read | enable mask |
| 0x43 | read | core status: bit 0 normal line, bit 1 fast line |
| 0x44 / 0x45 | write | enable set / enable clear (write 1 to act) |
| 0x46 | write | edge pending clear (write 1 to act) |
| 0x47 | write | end of interrupt (any value) |
| 0x48 / 0x49 | write | fast-force set / clear (write 1 to act) |
| 0x4A | read | fast-force status |
| 0x4B | read/write | spurious vector |
| 0x4C | read/write | debug control: bit 0 protect, bit 1 global mask |

Top module: `vpic_ctrl`

## Requirements
- R1: After reset, `nirq_o` and `fiq_o` are low, and the enable mask (0x42), fast-force status (0x4A) and debug control (0x4C) all read 0.
- R2: A write to 0x44 sets the enable bits written as 1, and a write to 0x45 clears them. Zero bits leave the mask unchanged, and 0x42 reads back the resulting mask.
- R3: A level source (mode bit 4 = 0) is pending while its synchronized input is high. An edge source (mode bit 4 = 1) becomes pending on a synchronized 0-to-1 transition. It stays pending, even after end of interrupt, until its bit is written as 1 to 0x46.
- R4: With the stack empty, `nirq_o` is high whenever an enabled, pending source that is not fast-routed exists. Bit 0 of 0x43 mirrors `nirq_o`, and bit 1 mirrors `fiq_o`.
- R5: The winner is the candidate with the highest priority, with the lowest index winning ties. A vector read returns the winner's vector word.
- R6: An acknowledge pushes the winner's priority. While the top of the stack holds level L, `nirq_o` asserts only for a candidate with priority greater than L.
- R7: Each write to 0x47 pops one level. Eight writes empty the stack from any state, and a write to an empty stack has no effect.
- R8: If no candidate outranks the stack top, a vector read returns the spurious vector (0x4B) and pushes nothing.
- R9: With debug bit 0 set, a vector read returns the vector and pushes nothing. A write of any value to 0x40 then performs the acknowledge push.
- R10: With debug bit 1 set, `nirq_o` and `fiq_o` stay low whatever sources are pending.
- R11: Source 0 and every source marked in the fast-force mask drive `fiq_o` when enabled and pending, and are excluded from the normal arbitration. 0x48 and 0x49 set and clear the mask with write-1 semantics, and 0x4A reads it.
- R12: 0x41 shows raw pending bits, including those of disabled sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| src_i | input | NUM_SRC | asynchronous interrupt source inputs |
| bus_sel | input | 1 | register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | word address |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, combinational |
| nirq_o | output | 1 | normal interrupt request |
| fiq_o | output | 1 | fast interrupt request |

## Verification
The bench builds the controller with its defaults: 32 sources and 3 priority bits, which gives an 8-level stack. That range covers the full source address space, including source 0's fixed fast routing. It also allows tie-breaks between equal priorities at distinct indices, and nested acknowledges at priorities 4 and 6. Eight end-of-interrupt writes issued against partly filled and empty stacks show that popping saturates. Edge and level sources at different priorities show the difference in pending retention across end of interrupt.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam int unsigned PRIO_W = 3;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 7;

  typedef logic [PRIO_W-1:0] prio_t;

  typedef struct packed {
    logic  edge_trig;
    prio_t prio;
  } src_mode_t;

  localparam logic [ADDR_W-1:0] A_VEC    = 7'h40;
  localparam logic [ADDR_W-1:0] A_PEND   = 7'h41;
  localparam logic [ADDR_W-1:0] A_ENMASK = 7'h42;
  localparam logic [ADDR_W-1:0] A_CORE   = 7'h43;
  localparam logic [ADDR_W-1:0] A_ENSET  = 7'h44;
  localparam logic [ADDR_W-1:0] A_ENCLR  = 7'h45;
  localparam logic [ADDR_W-1:0] A_PCLR   = 7'h46;
  localparam logic [ADDR_W-1:0] A_EOI    = 7'h47;
  localparam logic [ADDR_W-1:0] A_FFSET  = 7'h48;
  localparam logic [ADDR_W-1:0] A_FFCLR  = 7'h49;
  localparam logic [ADDR_W-1:0] A_FFSTAT = 7'h4A;
  localparam logic [ADDR_W-1:0] A_SPUR   = 7'h4B;
  localparam logic [ADDR_W-1:0] A_DBG    = 7'h4C;
endpackage

// File: rtl/vpic_src_front.sv
module vpic_src_front #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] edge_sel,
  input  logic [NUM_SRC-1:0] clr,
  output logic [NUM_SRC-1:0] pend
);
  logic [NUM_SRC-1:0] sync1, sync2, sync3, edge_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      sync3 <= '0;
    end else begin
      sync1 <= src_i;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     edge_pend[i] <= 1'b0;
      else if (sync2[i] && !sync3[i]) edge_pend[i] <= 1'b1;
      else if (clr[i])                edge_pend[i] <= 1'b0;
    end
    assign pend[i] = edge_sel[i] ? edge_pend[i] : sync2[i];
  end

  // R3
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((edge_pend & $past(edge_pend & ~clr)) == $past(edge_pend & ~clr)));
endmodule

// File: rtl/vpic_arbiter.sv
module vpic_arbiter
  import vpic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]             cand,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
  output logic                           found,
  output logic [IDX_W-1:0]               win_idx,
  output prio_t                          win_prio
);
  always_comb begin
    found    = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && (!found || prio[i] > win_prio)) begin
        found    = 1'b1;
        win_idx  = IDX_W'(i);
        win_prio = prio[i];
      end
    end
  end

  // R5
  always_comb begin
    if (found) begin
      win_valid_chk: assert (cand[win_idx]);
    end
  end
endmodule

// File: rtl/vpic_prio_stack.sv
module vpic_prio_stack
  import vpic_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned DW = $clog2(DEPTH + 1)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  prio_t push_prio,
  input  logic  pop,
  output logic  empty,
  output prio_t top_prio
);
  prio_t         stk [DEPTH];
  logic [DW-1:0] depth;
  logic [DW-1:0] depth_m1;

  assign depth_m1 = depth - 1'b1;
  assign empty    = (depth == '0);
  assign top_prio = empty ? '0 : stk[depth_m1[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth <= '0;
    end else if (push && depth < DW'(DEPTH)) begin
      depth <= depth + 1'b1;
    end else if (pop && !empty) begin
      depth <= depth_m1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && depth < DW'(DEPTH)) stk[depth[AW-1:0]] <= push_prio;
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> depth < DW'(DEPTH));
  // R7
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !empty) |=> depth == $past(depth) - 1'b1);
endmodule

// File: rtl/vpic_ctrl.sv
module vpic_ctrl
  import vpic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int unsigned STACK_DEPTH = 1 << PRIO_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [6:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               nirq_o,
  output logic               fiq_o
);
  src_mode_t          mode [NUM_SRC];
  logic [31:0]        vec  [NUM_SRC];
  logic [NUM_SRC-1:0] en, ff, pend, edge_sel, pclr, fast_mask, cand;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_flat;
  logic [31:0]        spur;
  logic [1:0]         dbg;
  logic               wr, rd, found, outrank, ack, push, pop, stk_empty;
  logic [IDX_W-1:0]   win_idx;
  prio_t              win_prio, top_prio;

  assign wr = bus_sel && bus_we;
  assign rd = bus_sel && !bus_we;

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      prio_flat[i] = mode[i].prio;
      edge_sel[i]  = mode[i].edge_trig;
    end
  end

  assign pclr = (wr && bus_addr == A_PCLR) ? bus_wdata[NUM_SRC-1:0] : '0;

  vpic_src_front #(.NUM_SRC(NUM_SRC)) i_front (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .edge_sel(edge_sel), .clr(pclr), .pend(pend)
  );

  assign fast_mask = ff | NUM_SRC'(1);
  assign cand      = pend & en & ~fast_mask;

  vpic_arbiter #(.NUM_SRC(NUM_SRC)) i_arb (
    .cand(cand), .prio(prio_flat),
    .found(found), .win_idx(win_idx), .win_prio(win_prio)
  );

  assign outrank = found && (stk_empty || win_prio > top_prio);
  assign ack  = (rd && bus_addr == A_VEC && !dbg[0]) ||
                (wr && bus_addr == A_VEC && dbg[0]);
  assign push = ack && outrank;
  assign pop  = wr && bus_addr == A_EOI;

  vpic_prio_stack #(.DEPTH(STACK_DEPTH)) i_stack (
    .clk(clk), .rst_n(rst_n), .push(push), .push_prio(win_prio),
    .pop(pop), .empty(stk_empty), .top_prio(top_prio)
  );

  assign nirq_o = outrank && !dbg[1];
  assign fiq_o  = (|(pend & en & fast_mask)) && !dbg[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= '0;
      ff   <= '0;
      spur <= '0;
      dbg  <= '0;
      for (int i = 0; i < NUM_SRC; i++) begin
        mode[i] <= '0;
        vec[i]  <= '0;
      end
    end else if (wr) begin
      unique case (bus_addr)
        A_ENSET: en   <= en | bus_wdata[NUM_SRC-1:0];
        A_ENCLR: en   <= en & ~bus_wdata[NUM_SRC-1:0];
        A_FFSET: ff   <= ff | bus_wdata[NUM_SRC-1:0];
        A_FFCLR: ff   <= ff & ~bus_wdata[NUM_SRC-1:0];
        A_SPUR:  spur <= bus_wdata;
        A_DBG:   dbg  <= bus_wdata[1:0];
        default: begin
          for (int i = 0; i < NUM_SRC; i++) begin
            if (bus_addr == {2'b00, 5'(i)}) mode[i] <= {bus_wdata[4], bus_wdata[PRIO_W-1:0]};
            if (bus_addr == {2'b01, 5'(i)}) vec[i]  <= bus_wdata;
          end
        end
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_VEC:    bus_rdata = outrank ? vec[win_idx] : spur;
      A_PEND:   bus_rdata = 32'(pend);
      A_ENMASK: bus_rdata = 32'(en);
      A_CORE:   bus_rdata = {30'd0, fiq_o, nirq_o};
      A_FFSTAT: bus_rdata = 32'(ff);
      A_SPUR:   bus_rdata = spur;
      A_DBG:    bus_rdata = {30'd0, dbg};
      default: begin
        for (int i = 0; i < NUM_SRC; i++) begin
          if (bus_addr == {2'b00, 5'(i)}) bus_rdata = {27'd0, mode[i].edge_trig, 1'b0, mode[i].prio};
          if (bus_addr == {2'b01, 5'(i)}) bus_rdata = vec[i];
        end
      end
    endcase
  end

  // R10
  gmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg[1] |-> (!nirq_o && !fiq_o));
  // R9
  protect_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr == A_VEC && dbg[0]) |=> ($stable(stk_empty) && $stable(top_prio)));
  // R6
  nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nirq_o && !stk_empty) |-> win_prio > top_prio);
  // R11
  fast_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (cand & fast_mask) == '0);
endmodule

// File: tb/test_vpic_ctrl.sv
module test_vpic_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        sel = 1'b0, we = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        nirq, fiq;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  vpic_ctrl i_vpic_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_sel(sel), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .nirq_o(nirq), .fiq_o(fiq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic brd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 nirq", 32'(nirq), 0);
    chk("R1 fiq", 32'(fiq), 0);
    brd(7'h42, d); chk("R1 enable", d, 0);
    brd(7'h4A, d); chk("R1 ffstat", d, 0);
    brd(7'h4C, d); chk("R1 dbg", d, 0);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    bwr(7'h44, 32'hF0); brd(7'h42, d); chk("R2 set", d, 32'hF0);
    bwr(7'h44, 32'h0);  brd(7'h42, d); chk("R2 zero set", d, 32'hF0);
    bwr(7'h45, 32'h30); brd(7'h42, d); chk("R2 clear", d, 32'hC0);
    bwr(7'h45, 32'h0);  brd(7'h42, d); chk("R2 zero clear", d, 32'hC0);
    bwr(7'h45, 32'hFFFF_FFFF);
  endtask

  task automatic t_config;
    for (int i = 0; i < 32; i++) bwr(7'h20 + 7'(i), 32'h1000 + i);
    bwr(7'h02, 32'h1);  bwr(7'h03, 32'h2);  bwr(7'h05, 32'h4);
    bwr(7'h07, 32'h13); bwr(7'h09, 32'h4);  bwr(7'h0C, 32'h6);
    bwr(7'h44, 32'h0000_12AD);
  endtask

  task automatic t_level;
    logic [31:0] d;
    src[3] = 1'b1; wt(5);
    brd(7'h41, d); chk("R12 pend level", d, 32'h08);
    chk("R4 nirq", 32'(nirq), 1);
    brd(7'h43, d); chk("R4 core status", d, 32'h1);
    src[3] = 1'b0; wt(5);
    brd(7'h41, d); chk("R3 level drop", d, 0);
    chk("R4 nirq low", 32'(nirq), 0);
    src[20] = 1'b1; wt(5);
    brd(7'h41, d); chk("R12 disabled pend", d, 32'h0010_0000);
    chk("R4 disabled no nirq", 32'(nirq), 0);
    src[20] = 1'b0; wt(5);
  endtask

  task automatic t_arb;
    logic [31:0] d;
    src[2] = 1'b1; src[5] = 1'b1; src[9] = 1'b1; wt(5);
    brd(7'h40, d); chk("R5 winner tie", d, 32'h1005);
    chk("R6 held off equal", 32'(nirq), 0);
    src[12] = 1'b1; wt(5);
    chk("R6 higher passes", 32'(nirq), 1);
    brd(7'h40, d); chk("R5 higher vector", d, 32'h100C);
    chk("R6 level 6 held", 32'(nirq), 0);
    bwr(7'h47, 0); wt(1);
    chk("R7 pop to 4", 32'(nirq), 1);
    src[12] = 1'b0; wt(5);
    chk("R6 level 4 held", 32'(nirq), 0);
    bwr(7'h47, 0); wt(1);
    chk("R7 pop to empty", 32'(nirq), 1);
    for (int k = 0; k < 8; k++) bwr(7'h47, 0);
    chk("R7 empty pops", 32'(nirq), 1);
    brd(7'h40, d); chk("R6 push again", 32'(nirq), 0);
    for (int k = 0; k < 8; k++) bwr(7'h47, 0);
    chk("R7 eight pops empty", 32'(nirq), 1);
    src[2] = 1'b0; src[5] = 1'b0; src[9] = 1'b0; wt(5);
  endtask

  task automatic t_spur;
    logic [31:0] d;
    bwr(7'h4B, 32'hDEAD);
    brd(7'h40, d); chk("R8 idle spurious", d, 32'hDEAD);
    src[5] = 1'b1; wt(5);
    brd(7'h40, d); chk("R5 vector", d, 32'h1005);
    brd(7'h40, d); chk("R8 held spurious", d, 32'hDEAD);
    bwr(7'h47, 0); wt(1);
    chk("R8 single push", 32'(nirq), 1);
    src[5] = 1'b0; wt(5);
  endtask

  task automatic t_edge;
    logic [31:0] d;
    src[7] = 1'b1; wt(3); src[7] = 1'b0; wt(5);
    brd(7'h41, d); chk("R3 edge pend", d, 32'h80);
    chk("R3 edge nirq", 32'(nirq), 1);
    brd(7'h40, d); chk("R5 edge vector", d, 32'h1007);
    chk("R6 edge held", 32'(nirq), 0);
    bwr(7'h47, 0); wt(1);
    chk("R3 pending after eoi", 32'(nirq), 1);
    bwr(7'h46, 32'h80); wt(1);
    brd(7'h41, d); chk("R3 cleared", d, 0);
    chk("R3 nirq after clear", 32'(nirq), 0);
  endtask

  task automatic t_protect;
    logic [31:0] d;
    bwr(7'h4C, 32'h1);
    src[5] = 1'b1; wt(5);
    brd(7'h40, d); chk("R9 read1", d, 32'h1005);
    brd(7'h40, d); chk("R9 read2", d, 32'h1005);
    chk("R9 no push", 32'(nirq), 1);
    bwr(7'h40, 0); wt(1);
    chk("R9 write push", 32'(nirq), 0);
    bwr(7'h47, 0); wt(1);
    chk("R9 pop", 32'(nirq), 1);
    bwr(7'h4C, 32'h0);
  endtask

  task automatic t_gmask;
    bwr(7'h4C, 32'h2); wt(1);
    chk("R10 nirq masked", 32'(nirq), 0);
    src[0] = 1'b1; wt(5);
    chk("R10 fiq masked", 32'(fiq), 0);
    bwr(7'h4C, 32'h0); wt(1);
    chk("R10 nirq unmasked", 32'(nirq), 1);
    chk("R10 fiq unmasked", 32'(fiq), 1);
    src[0] = 1'b0; wt(5);
  endtask

  task automatic t_fast;
    logic [31:0] d;
    bwr(7'h48, 32'h20); wt(1);
    chk("R11 forced nirq", 32'(nirq), 0);
    chk("R11 forced fiq", 32'(fiq), 1);
    brd(7'h4A, d); chk("R11 ffstat", d, 32'h20);
    bwr(7'h48, 32'h0); brd(7'h4A, d); chk("R11 zero set", d, 32'h20);
    bwr(7'h49, 32'h20); wt(1);
    brd(7'h4A, d); chk("R11 ff cleared", d, 0);
    chk("R11 back normal", 32'(nirq), 1);
    chk("R11 fiq off", 32'(fiq), 0);
    src[5] = 1'b0; src[0] = 1'b1; wt(5);
    chk("R11 src0 fiq", 32'(fiq), 1);
    chk("R11 src0 no nirq", 32'(nirq), 0);
    brd(7'h43, d); chk("R4 core fiq bit", d, 32'h2);
    src[0] = 1'b0; wt(5);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    wt(3);
    rst_n = 1'b1;
    wt(2);
    t_reset();
    t_enable();
    t_config();
    t_level();
    t_arb();
    t_spur();
    t_edge();
    t_protect();
    t_gmask();
    t_fast();
    finish_run();
  end

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end
endmodule